// File: doc/BRIEF.md
# Binned Peak Centroid Decoder

This block turns the two rows of 32 binned activations that a track-finding classifier produces into two fixed-point track parameters. One row covers the intercept (32 bins of 0.625 cm from 0 to 20 cm). The other covers the slope (32 bins of 50 mrad from -0.8 rad to +0.8 rad). For each row the block picks the strongest bin. It then takes the activation-weighted mean of the bin centres over that bin and up to two neighbours on either side. The result has a resolution finer than one bin, because the classifier spreads each answer over three or four adjacent bins.

A frame of 64 unsigned 8-bit activations is taken over a valid/ready handshake. Both rows pass through the same arg-max, window-sum and shift-subtract divider structure in parallel, so the two results appear together after a fixed number of cycles. The output is one pulse with both values. A row whose window holds no activation at all reports the centre of its peak bin and raises a flag.

Top module: `peak_centroid_decoder`

## Requirements
- R1: After reset `in_ready` is high. A frame is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the next cycle until the result has been delivered. `in_valid` is ignored while `in_ready` is low, and so is the data on `in_act`.
- R2: `out_valid` is high for exactly one cycle, the cycle that follows the 25th rising edge after the accepting edge (NUM_W+1 edges, NUM_W = 24 by default). `in_ready` returns high in the cycle after that pulse.
- R3: Activation of bin b sits in `in_act[8*b+7 : 8*b]`. Bins 0 to 31 form the intercept row. Bins 32 to 63 form the slope row, holding slope bins 0 to 31 in that order.
- R4: The peak of a row is the bin with the largest activation. Among equal maxima the lowest bin index wins.
- R5: The averaging window is the peak bin ±2. Bins beyond either end of the row are left out, and the weights are normalised over the bins that remain.
- R6: `out_icept` = floor(256 · Σ w(j)·(j+0.5) / Σ w(j)) over the window, unsigned, in units of 1/256 of a bin (0.625/256 cm per LSB, measured from 0 cm).
- R7: `out_slope` is the slope row's value under the R6 formula minus 4096, as a signed two's-complement number in units of 50/256 mrad measured from 0 rad.
- R8: If every activation in a row's window is zero, that row reports its peak bin centre ((2p+1)·128 before the R7 offset) and its zero flag is high in the `out_valid` cycle. Otherwise the flag is low.
- R9: The two rows are decoded independently. The contents of one row never change the other row's value or flag.
- R10: During and directly after reset `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame is offered on `in_act` |
| in_ready | output | 1 | Block can take a frame |
| in_act | input | 512 | 64 activations, 8 bits each (R3) |
| out_valid | output | 1 | One-cycle result pulse |
| out_icept | output | 13 | Intercept, 1/256 bin units |
| out_slope | output | 14 | Signed slope, 1/256 bin units |
| out_icept_zero | output | 1 | Intercept window was all zero |
| out_slope_zero | output | 1 | Slope window was all zero |

## Verification
The hardest situation to reach from the ports is a peak that sits on a row edge while the activation just outside the clipped window is large. Only then does a clipping error change the centroid. Directed frames place the maximum on bins 0, 1, 30 and 31 with heavy bins placed just beyond the window. Tied maxima at distant bins are also driven. A stream of frames is then offered with `in_valid` held high and the data changing every cycle while the block is busy. Any capture of a frame that should have been ignored then shows up as a wrong centroid.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    localparam int unsigned ACT_W_DEF = 8;
    localparam int unsigned NBIN_DEF  = 32;
    localparam int unsigned HALF_DEF  = 2;
    localparam int unsigned FRAC_DEF  = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FIND = 2'd1,
        PH_DIV  = 2'd2
    } phase_e;

endpackage

// File: rtl/pcd_argmax.sv
module pcd_argmax #(
    parameter int NBIN  = 32,
    parameter int ACT_W = 8,
    parameter int IDX_W = $clog2(NBIN)
) (
    input  logic [NBIN-1:0][ACT_W-1:0] act,
    output logic [IDX_W-1:0]           peak
);

    logic [ACT_W-1:0] best;

    // strict compare keeps the lowest index among equal maxima
    always_comb begin
        best = act[0];
        peak = '0;
        for (int i = 1; i < NBIN; i++) begin
            if (act[i] > best) begin
                best = act[i];
                peak = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pcd_window.sv
module pcd_window #(
    parameter int NBIN   = 32,
    parameter int ACT_W  = 8,
    parameter int HALF   = 2,
    parameter int IDX_W  = $clog2(NBIN),
    parameter int DEN_W  = ACT_W + $clog2(2*HALF+1),
    parameter int WSUM_W = DEN_W + IDX_W + 1
) (
    input  logic [NBIN-1:0][ACT_W-1:0] act,
    input  logic [IDX_W-1:0]           peak,
    output logic [DEN_W-1:0]           den,
    output logic [WSUM_W-1:0]          wsum
);

    // wsum holds sum of w*(2j+1): bin centres in half-bin units
    always_comb begin
        den  = '0;
        wsum = '0;
        for (int k = -HALF; k <= HALF; k++) begin
            int j;
            j = int'(peak) + k;
            if (j >= 0 && j < NBIN) begin
                den  = den + DEN_W'(act[j[IDX_W-1:0]]);
                wsum = wsum + WSUM_W'(act[j[IDX_W-1:0]]) * WSUM_W'(2*j + 1);
            end
        end
    end

endmodule

// File: rtl/pcd_divider.sv
module pcd_divider #(
    parameter int NUM_W = 24,
    parameter int DEN_W = 11,
    parameter int QUO_W = 13,
    localparam int CNT_W = $clog2(NUM_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [QUO_W-1:0] quo,
    output logic             done
);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [NUM_W-1:0] acc;
        logic [DEN_W-1:0] rem;
        logic [DEN_W-1:0] den;
    } div_t;

    div_t q, d;
    logic [DEN_W:0] rem_sh;
    logic           qbit;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        rem_sh = {q.rem, q.acc[NUM_W-1]};
        qbit   = 1'b0;
        if (q.busy) begin
            if (rem_sh >= {1'b0, q.den}) begin
                d.rem = DEN_W'(rem_sh - {1'b0, q.den});
                qbit  = 1'b1;
            end else begin
                d.rem = rem_sh[DEN_W-1:0];
            end
            d.acc = {q.acc[NUM_W-2:0], qbit};
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CNT_W'(NUM_W - 1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end else if (start) begin
            d.busy = 1'b1;
            d.cnt  = '0;
            d.acc  = num;
            d.rem  = '0;
            d.den  = den;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign quo  = q.acc[QUO_W-1:0];
    assign done = q.done;

    // R6
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.den != '0) |-> (q.rem < q.den));

    // R2
    div_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

endmodule

// File: rtl/peak_centroid_decoder.sv
module peak_centroid_decoder
    import pcd_pkg::*;
#(
    parameter int ACT_W = ACT_W_DEF,
    parameter int NBIN  = NBIN_DEF,
    parameter int HALF  = HALF_DEF,
    parameter int FRAC  = FRAC_DEF,
    localparam int NGRP   = 2,
    localparam int IDX_W  = $clog2(NBIN),
    localparam int DEN_W  = ACT_W + $clog2(2*HALF+1),
    localparam int WSUM_W = DEN_W + IDX_W + 1,
    localparam int NUM_W  = WSUM_W + FRAC - 1,
    localparam int Q_W    = IDX_W + FRAC
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [NGRP*NBIN*ACT_W-1:0]    in_act,
    output logic                          out_valid,
    output logic [Q_W-1:0]                out_icept,
    output logic signed [Q_W:0]           out_slope,
    output logic                          out_icept_zero,
    output logic                          out_slope_zero
);

    localparam logic signed [Q_W:0] SLOPE_OFS = (Q_W+1)'((NBIN/2) << FRAC);

    typedef struct packed {
        phase_e                                phase;
        logic [NGRP-1:0][NBIN-1:0][ACT_W-1:0] frame;
        logic [NGRP-1:0][IDX_W-1:0]            peak;
        logic [NGRP-1:0]                       zero;
    } st_t;

    st_t q, d;

    logic [NGRP-1:0][IDX_W-1:0]  peak_w;
    logic [NGRP-1:0][DEN_W-1:0]  den_w;
    logic [NGRP-1:0][WSUM_W-1:0] wsum_w;
    logic [NGRP-1:0][Q_W-1:0]    quo_w;
    logic [NGRP-1:0]             done_w;
    logic [NGRP-1:0][Q_W-1:0]    pos;
    logic                        div_start;

    assign div_start = (q.phase == PH_FIND);

    for (genvar g = 0; g < NGRP; g++) begin : g_row
        pcd_argmax #(.NBIN(NBIN), .ACT_W(ACT_W), .IDX_W(IDX_W)) u_max (
            .act  (q.frame[g]),
            .peak (peak_w[g])
        );

        pcd_window #(.NBIN(NBIN), .ACT_W(ACT_W), .HALF(HALF), .IDX_W(IDX_W),
                     .DEN_W(DEN_W), .WSUM_W(WSUM_W)) u_win (
            .act  (q.frame[g]),
            .peak (peak_w[g]),
            .den  (den_w[g]),
            .wsum (wsum_w[g])
        );

        pcd_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W), .QUO_W(Q_W)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .start (div_start),
            .num   (NUM_W'(wsum_w[g]) << (FRAC - 1)),
            .den   (den_w[g]),
            .quo   (quo_w[g]),
            .done  (done_w[g])
        );

        assign pos[g] = q.zero[g] ? (Q_W'({q.peak[g], 1'b1}) << (FRAC - 1)) : quo_w[g];

        logic beaten;
        always_comb begin
            beaten = 1'b0;
            for (int i = 0; i < NBIN; i++) begin
                if (q.frame[g][i] > q.frame[g][peak_w[g]] ||
                    (i < int'(peak_w[g]) && q.frame[g][i] == q.frame[g][peak_w[g]]))
                    beaten = 1'b1;
            end
        end

        // R4
        peak_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q.phase == PH_FIND) |-> !beaten);
    end

    always_comb begin
        d = q;
        case (q.phase)
            PH_IDLE: begin
                if (in_valid) begin
                    d.frame = in_act;
                    d.phase = PH_FIND;
                end
            end
            PH_FIND: begin
                for (int g = 0; g < NGRP; g++) begin
                    d.peak[g] = peak_w[g];
                    d.zero[g] = (den_w[g] == '0);
                end
                d.phase = PH_DIV;
            end
            PH_DIV: begin
                if (done_w[0]) d.phase = PH_IDLE;
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready       = (q.phase == PH_IDLE);
    assign out_valid      = done_w[0];
    assign out_icept      = pos[0];
    assign out_slope      = signed'({1'b0, pos[1]}) - SLOPE_OFS;
    assign out_icept_zero = q.zero[0];
    assign out_slope_zero = q.zero[1];

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> (!out_valid && in_ready));

    // R1
    accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R1
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !out_valid) |=> !in_ready);

    // R9
    row_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_w[0] == done_w[1]);

    // R5
    window_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_icept_zero) |->
        ((int'(out_icept) - int'({q.peak[0], 1'b1}) * (2 ** (FRAC - 1)) <= HALF * (2 ** FRAC)) &&
         (int'({q.peak[0], 1'b1}) * (2 ** (FRAC - 1)) - int'(out_icept) <= HALF * (2 ** FRAC))));

    // R8
    zero_centre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_icept_zero) |-> (out_icept == Q_W'(2 ** (FRAC - 1))));

endmodule

// File: tb/peak_centroid_decoder_tb.sv
`timescale 1ns/1ps
module peak_centroid_decoder_tb;

    localparam int LAT = 25;   // R2: edges from accept to result

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [511:0]       in_act = '0;
    logic               out_valid;
    logic [12:0]        out_icept;
    logic signed [13:0] out_slope;
    logic               out_icept_zero;
    logic               out_slope_zero;

    always #2.5 clk = ~clk;

    peak_centroid_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_act(in_act), .out_valid(out_valid), .out_icept(out_icept),
        .out_slope(out_slope), .out_icept_zero(out_icept_zero),
        .out_slope_zero(out_slope_zero)
    );

    typedef struct {
        int    icept;
        int    slope;
        bit    iz;
        bit    sz;
        int    due;
        string tag;
    } exp_t;

    exp_t  expq[$];
    int    ecnt = 0;
    int    last_acc = -1000;
    int    nchk = 0;
    int    nfail = 0;
    bit    checking = 1'b0;
    bit    finished = 1'b0;
    string cur_tag = "R6";
    logic [511:0] f;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // behavioural reference for one row (R4, R5, R6, R8)
    function automatic void ref_row(input logic [511:0] fr, input int base,
                                    output int pos, output bit z);
        int best = -1, pk = 0, den = 0, num = 0, v;
        for (int i = 0; i < 32; i++) begin
            v = int'(fr[(base + i) * 8 +: 8]);
            if (v > best) begin best = v; pk = i; end
        end
        for (int j = pk - 2; j <= pk + 2; j++) begin
            if (j >= 0 && j < 32) begin
                v = int'(fr[(base + j) * 8 +: 8]);
                den += v;
                num += v * (2 * j + 1) * 128;
            end
        end
        if (den == 0) begin pos = (2 * pk + 1) * 128; z = 1'b1; end
        else          begin pos = num / den;          z = 1'b0; end
    endfunction

    always @(posedge clk) begin
        exp_t e;
        int   p;
        bit   z;
        ecnt++;
        if (rst_n && in_valid && in_ready) begin
            ref_row(in_act, 0, p, z);
            e.icept = p; e.iz = z;
            ref_row(in_act, 32, p, z);
            e.slope = p - 4096; e.sz = z;   // R7
            e.due = ecnt + LAT;
            e.tag = cur_tag;
            expq.push_back(e);
            last_acc = ecnt;
        end
    end

    always @(negedge clk) begin
        bit ev, er;
        if (rst_n && checking) begin
            ev = (expq.size() > 0) && (expq[0].due == ecnt);
            er = !(ecnt <= last_acc + LAT);
            chk(out_valid == ev, "R2 out_valid", int'(out_valid), int'(ev));
            chk(in_ready == er, "R1 in_ready", int'(in_ready), int'(er));
            if (ev) begin
                chk(int'(out_icept) == expq[0].icept, {expq[0].tag, " icept"},
                    int'(out_icept), expq[0].icept);
                chk(int'(out_slope) == expq[0].slope, {expq[0].tag, " R7 slope"},
                    int'(out_slope), expq[0].slope);
                chk(out_icept_zero == expq[0].iz, {expq[0].tag, " R8 icept_zero"},
                    int'(out_icept_zero), int'(expq[0].iz));
                chk(out_slope_zero == expq[0].sz, {expq[0].tag, " R8 slope_zero"},
                    int'(out_slope_zero), int'(expq[0].sz));
                void'(expq.pop_front());
            end
        end
    end

    // watchdog
    always @(negedge clk) begin
        if (ecnt > 60000 && !finished) begin
            finished = 1'b1;
            nfail++;
            $display("FAIL watchdog expired actual=%0d expected=0", ecnt);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    task automatic put(input int bin, input int v);
        f[bin * 8 +: 8] = 8'(v);
    endtask

    task automatic send(input string tag);
        @(negedge clk);
        cur_tag  = tag;
        in_act   = f;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_act   = ~f;   // junk while busy, must be ignored (R1)
    endtask

    task automatic gauss_row(input int base, input int c, input int amp);
        int d, v;
        for (int i = 0; i < 32; i++) begin
            d = (i > c) ? i - c : c - i;
            case (d)
                0: v = amp;
                1: v = amp * 5 / 8;
                2: v = amp / 4;
                3: v = amp / 16;
                default: v = 0;
            endcase
            v = v + int'($urandom_range(0, 3));
            if (v > 255) v = 255;
            put(base + i, v);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        chk(out_valid == 1'b0, "R10 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R10 R1 in_ready after reset", int'(in_ready), 1);
        checking = 1'b1;

        // R3 R6: mid-row peaks, slope row in upper byte lanes
        f = '0;
        put(10, 40); put(11, 200); put(12, 120); put(13, 10);
        put(32 + 20, 90); put(32 + 21, 160); put(32 + 22, 30);
        send("R3/R6");

        // R5: peaks on both edges, heavy bins just outside the clipped window
        f = '0;
        put(0, 200); put(1, 100); put(2, 20); put(3, 190);
        put(32 + 31, 250); put(32 + 30, 100); put(32 + 28, 240);
        send("R5 edge");

        // R5: peaks one bin from the edge
        f = '0;
        put(0, 60); put(1, 220); put(2, 80); put(3, 30); put(4, 210);
        put(32 + 30, 230); put(32 + 31, 90); put(32 + 29, 15); put(32 + 27, 200);
        send("R5 near edge");

        // R4: tied maxima, lower index wins
        f = '0;
        put(5, 180); put(6, 50); put(20, 180); put(21, 170);
        put(32 + 7, 200); put(32 + 8, 200); put(32 + 9, 60);
        send("R4 tie");

        // R8 R9: intercept row empty, slope row single bin 16
        f = '0;
        put(32 + 16, 77);
        send("R8/R9 one empty");

        // R8: both rows empty
        f = '0;
        send("R8 all zero");

        // R4 R5: every bin at full scale
        f = '1;
        send("R4/R5 saturated");

        // R6: Gaussian-like shapes at random centres
        for (int n = 0; n < 20; n++) begin
            gauss_row(0, int'($urandom_range(0, 31)), int'($urandom_range(60, 250)));
            gauss_row(32, int'($urandom_range(0, 31)), int'($urandom_range(60, 250)));
            send("R6 gauss");
        end

        // R1: in_valid held high, data changing every cycle, including while busy
        cur_tag = "R1 stream";
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            for (int w = 0; w < 16; w++) in_act[w * 32 +: 32] = $urandom;
            in_valid = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0;

        // R6: sparse random frames
        for (int n = 0; n < 10; n++) begin
            f = '0;
            for (int k = 0; k < 6; k++) put(int'($urandom_range(0, 63)), int'($urandom_range(0, 255)));
            send("R6 sparse");
        end

        while (expq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule